// File: doc/BRIEF.md
# Muon Output Word Packer

This block turns the four best muon candidates of a trigger sorter into four 32-bit words that are sent downstream on each 40 MHz crossing. For each candidate it looks up a transverse momentum and a quality code from the rank and the valid-charge flag. It also looks up a global phi from the local phi and the source ID, and it decodes a global eta from the local eta and the source ID. These results are packed together with the candidate's sign and halo flags and with the crossing-wide bunch counter, bunch-zero marker and sync-error flag.

Both lookup tables are writable through a single host write port. Each lane has its own read port on the shared table storage, so all four candidates are converted in the same cycle. The conversion stage is registered and the output word is registered again. A word therefore appears two clock edges after its candidate is presented.

Top module: `muon_word_packer`

## Requirements
- R1: While `rst_n` is low, every output word is zero. The words stay zero on the first clock edge after reset is released.
- R2: The momentum/quality table is read at address `{vc, rank[6:0]}` (`vc` on address bit 7). The 5 low data bits go to word bits 12:8 as momentum, and the 3 high data bits go to bits 15:13 as quality.
- R3: The phi table is read at address `{src[3:0], lphi[4:0]}` (source ID on address bits 8:5). Its 8-bit data goes to word bits 7:0.
- R4: Word bits 21:16 hold the global eta. Bit 21 is 1 when the source ID is 6 or more. Bits 20:16 are `leta + off`, where `off` is `src` for sources 0 to 5 and `src - 6` otherwise. This sum saturates at 31.
- R5: The remaining bits are as follows: halo in bit 22, sign in bit 23, valid charge in bit 24, the 3-bit bunch counter in bits 27:25, bunch-zero in bit 28, sync error in bit 29. Bits 31:30 are always 0.
- R6: The word for a candidate presented before clock edge k is visible after edge k+1. A new candidate set can be accepted on every cycle.
- R7: Lane i (bits 32*i+31 : 32*i of `word_o`) depends only on lane i's candidate fields and on the shared crossing fields.
- R8: A host write with `host_sel`=0 stores `host_wdata` in the momentum/quality table at `host_addr[7:0]`. A host write with `host_sel`=1 stores it in the phi table at `host_addr[8:0]`. The new entry is seen by candidates presented on any later cycle.
- R9: A candidate presented in the same cycle as a host write to the address it reads gets the entry's previous contents. Words already in the pipeline are not changed by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_rank | input | NUM_LANES*RANK_W | Rank per lane |
| cand_vc | input | NUM_LANES | Valid-charge flag per lane |
| cand_lphi | input | NUM_LANES*LPHI_W | Local phi per lane |
| cand_src | input | NUM_LANES*SRC_W | Source ID per lane |
| cand_leta | input | NUM_LANES*LETA_W | Local eta per lane |
| cand_sign | input | NUM_LANES | Charge sign per lane |
| cand_halo | input | NUM_LANES | Halo flag per lane |
| bx_num | input | BX_W | Bunch counter for this crossing |
| bx_zero | input | 1 | Bunch-zero marker |
| sync_err | input | 1 | Synchronisation error flag |
| host_we | input | 1 | Table write strobe |
| host_sel | input | 1 | Table select: 0 momentum/quality, 1 phi |
| host_addr | input | HOST_AW | Table write address |
| host_wdata | input | 8 | Table write data |
| word_o | output | NUM_LANES*32 | Packed output words, lane 0 lowest |

## Verification
The bench builds the block with its default parameters: four lanes, a 7-bit rank, a 5-bit local phi, a 4-bit source ID and saturating eta. With these values both tables have their full 256 and 512 entries, and the bench fills every entry, so any address a random candidate picks is covered by the model. A 4-bit source ID reaches both eta sign halves and offsets up to 9. Together with a local eta of 31, this drives the sum past the saturation point. Random host writes mixed into the candidate stream, plus directed same-address collisions, exercise the read-before-write ordering.

// File: rtl/mwp_pkg.sv
package mwp_pkg;

   localparam int WORD_W      = 32;
   localparam int PT_W        = 5;
   localparam int QUAL_W      = 3;
   localparam int GPHI_W      = 8;
   localparam int ETA_MAG_W   = 5;
   localparam int GETA_W      = ETA_MAG_W + 1;
   localparam int BX_W        = 3;
   localparam int LUT_DW      = 8;
   localparam int ETA_FAR_SRC = 6;

   // per-lane results held in the conversion stage
   typedef struct packed {
      logic              halo;
      logic              sign;
      logic              vc;
      logic [GETA_W-1:0] geta;
   } lane_t;

   // crossing-wide flags shared by all lanes
   typedef struct packed {
      logic [BX_W-1:0] bx;
      logic            bc0;
      logic            se;
   } xing_t;

   // downstream word, most significant field first
   typedef struct packed {
      logic [1:0]        pad;
      logic              se;
      logic              bc0;
      logic [BX_W-1:0]   bx;
      logic              vc;
      logic              sign;
      logic              halo;
      logic [GETA_W-1:0] eta;
      logic [QUAL_W-1:0] qual;
      logic [PT_W-1:0]   pt;
      logic [GPHI_W-1:0] phi;
   } muon_word_t;

endpackage

// File: rtl/mwp_table.sv
module mwp_table #(
   parameter int AW  = 8,
   parameter int DW  = 8,
   parameter int NRD = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [NRD*AW-1:0] rd_addr,
   output logic [NRD*DW-1:0] rd_data
);

   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $fatal(1, "mwp_table: AW out of range");
   end
   if (NRD < 1) begin : g_bad_nrd
      $fatal(1, "mwp_table: NRD must be positive");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   // registered reads sample the array before this edge's write lands
   for (genvar r = 0; r < NRD; r++) begin : g_rd
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else        q <= mem[rd_addr[r*AW +: AW]];
      end
      assign rd_data[r*DW +: DW] = q;
   end

endmodule

// File: rtl/mwp_eta_dec.sv
module mwp_eta_dec #(
   parameter int SRC_W    = 4,
   parameter int LETA_W   = 5,
   parameter int FAR_SRC  = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic [SRC_W-1:0]  src,
   input  logic [LETA_W-1:0] leta,
   output logic [LETA_W:0]   geta
);

   localparam int SUM_W = ((LETA_W > SRC_W) ? LETA_W : SRC_W) + 1;
   localparam logic [SUM_W-1:0] MAG_MAX = SUM_W'((1 << LETA_W) - 1);
   localparam logic [SUM_W-1:0] FAR_OFS = SUM_W'(FAR_SRC);

   if (FAR_SRC < 1 || FAR_SRC >= (1 << SRC_W)) begin : g_bad_far
      $fatal(1, "mwp_eta_dec: FAR_SRC must split the source range");
   end

   logic             far;
   logic [SUM_W-1:0] off;
   logic [SUM_W-1:0] sum;

   always_comb begin
      far = (SUM_W'(src) >= FAR_OFS);
      off = far ? (SUM_W'(src) - FAR_OFS) : SUM_W'(src);
      sum = SUM_W'(leta) + off;
   end

   if (SATURATE) begin : g_sat
      assign geta = {far, (sum > MAG_MAX) ? MAG_MAX[LETA_W-1:0] : sum[LETA_W-1:0]};
   end else begin : g_wrap
      assign geta = {far, sum[LETA_W-1:0]};
   end

endmodule

// File: rtl/mwp_packer.sv
module mwp_packer
   import mwp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LUT_DW-1:0] ptq,
   input  logic [LUT_DW-1:0] gphi,
   input  lane_t             lane,
   input  xing_t             xing,
   output logic [WORD_W-1:0] word
);

   muon_word_t w;

   always_comb begin
      w      = '0;
      w.phi  = gphi[GPHI_W-1:0];
      w.pt   = ptq[PT_W-1:0];
      w.qual = ptq[LUT_DW-1 -: QUAL_W];
      w.eta  = lane.geta;
      w.halo = lane.halo;
      w.sign = lane.sign;
      w.vc   = lane.vc;
      w.bx   = xing.bx;
      w.bc0  = xing.bc0;
      w.se   = xing.se;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) word <= '0;
      else        word <= w;
   end

endmodule

// File: rtl/muon_word_packer.sv
module muon_word_packer
   import mwp_pkg::*;
#(
   parameter int NUM_LANES    = 4,
   parameter int RANK_W       = 7,
   parameter int LPHI_W       = 5,
   parameter int SRC_W        = 4,
   parameter int LETA_W       = 5,
   parameter int BX_W         = 3,
   parameter bit ETA_SATURATE = 1'b1,
   parameter int FAR_SRC      = mwp_pkg::ETA_FAR_SRC,
   localparam int PTQ_AW  = RANK_W + 1,
   localparam int PHI_AW  = LPHI_W + SRC_W,
   localparam int HOST_AW = (PTQ_AW > PHI_AW) ? PTQ_AW : PHI_AW,
   localparam int OUT_W   = mwp_pkg::WORD_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LANES*RANK_W-1:0] cand_rank,
   input  logic [NUM_LANES-1:0]        cand_vc,
   input  logic [NUM_LANES*LPHI_W-1:0] cand_lphi,
   input  logic [NUM_LANES*SRC_W-1:0]  cand_src,
   input  logic [NUM_LANES*LETA_W-1:0] cand_leta,
   input  logic [NUM_LANES-1:0]        cand_sign,
   input  logic [NUM_LANES-1:0]        cand_halo,
   input  logic [BX_W-1:0]             bx_num,
   input  logic                        bx_zero,
   input  logic                        sync_err,
   input  logic                        host_we,
   input  logic                        host_sel,
   input  logic [HOST_AW-1:0]          host_addr,
   input  logic [7:0]                  host_wdata,
   output logic [NUM_LANES*OUT_W-1:0]  word_o
);

   // elaboration-time parameter checks
   if (NUM_LANES < 1) begin : g_bad_lanes
      $fatal(1, "muon_word_packer: NUM_LANES must be positive");
   end
   if (LETA_W != ETA_MAG_W) begin : g_bad_eta
      $fatal(1, "muon_word_packer: LETA_W must match the word eta field");
   end
   if (BX_W != mwp_pkg::BX_W) begin : g_bad_bx
      $fatal(1, "muon_word_packer: BX_W must match the word crossing field");
   end
   if ($bits(muon_word_t) != OUT_W) begin : g_bad_word
      $fatal(1, "muon_word_packer: word layout does not fill the word");
   end
   if (PTQ_AW > 12 || PHI_AW > 12) begin : g_bad_depth
      $fatal(1, "muon_word_packer: table address too wide");
   end

   // host write decode
   logic ptq_we, phi_we;
   assign ptq_we = host_we & ~host_sel;
   assign phi_we = host_we &  host_sel;

   logic [NUM_LANES*PTQ_AW-1:0] ptq_raddr;
   logic [NUM_LANES*PHI_AW-1:0] phi_raddr;
   logic [NUM_LANES*LUT_DW-1:0] ptq_rdata;
   logic [NUM_LANES*LUT_DW-1:0] phi_rdata;

   mwp_table #(.AW(PTQ_AW), .DW(LUT_DW), .NRD(NUM_LANES)) u_ptq_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ptq_we),
      .wr_addr (host_addr[PTQ_AW-1:0]),
      .wr_data (host_wdata),
      .rd_addr (ptq_raddr),
      .rd_data (ptq_rdata)
   );

   mwp_table #(.AW(PHI_AW), .DW(LUT_DW), .NRD(NUM_LANES)) u_phi_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (phi_we),
      .wr_addr (host_addr[PHI_AW-1:0]),
      .wr_data (host_wdata),
      .rd_addr (phi_raddr),
      .rd_data (phi_rdata)
   );

   // crossing flags, conversion stage
   xing_t xing_q;
   always_ff @(posedge clk) begin
      if (!rst_n) xing_q <= '0;
      else        xing_q <= '{bx: bx_num, bc0: bx_zero, se: sync_err};
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [SRC_W-1:0]  src;
      logic [GETA_W-1:0] geta;
      lane_t             lane_q;

      assign src = cand_src[l*SRC_W +: SRC_W];
      assign ptq_raddr[l*PTQ_AW +: PTQ_AW] = {cand_vc[l], cand_rank[l*RANK_W +: RANK_W]};
      assign phi_raddr[l*PHI_AW +: PHI_AW] = {src, cand_lphi[l*LPHI_W +: LPHI_W]};

      mwp_eta_dec #(
         .SRC_W    (SRC_W),
         .LETA_W   (LETA_W),
         .FAR_SRC  (FAR_SRC),
         .SATURATE (ETA_SATURATE)
      ) u_eta (
         .src  (src),
         .leta (cand_leta[l*LETA_W +: LETA_W]),
         .geta (geta)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) lane_q <= '0;
         else        lane_q <= '{halo: cand_halo[l], sign: cand_sign[l],
                                 vc: cand_vc[l], geta: geta};
      end

      mwp_packer u_pack (
         .clk   (clk),
         .rst_n (rst_n),
         .ptq   (ptq_rdata[l*LUT_DW +: LUT_DW]),
         .gphi  (phi_rdata[l*LUT_DW +: LUT_DW]),
         .lane  (lane_q),
         .xing  (xing_q),
         .word  (word_o[l*OUT_W +: OUT_W])
      );
   end

endmodule

// File: rtl/mwp_checker.sv
module mwp_checker #(
   parameter int NUM_LANES = 4,
   parameter int SRC_W     = 4,
   parameter int LETA_W    = 5,
   parameter int BX_W      = 3,
   parameter int FAR_SRC   = 6
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_LANES-1:0]        cand_vc,
   input logic [NUM_LANES*SRC_W-1:0]  cand_src,
   input logic [NUM_LANES*LETA_W-1:0] cand_leta,
   input logic [BX_W-1:0]             bx_num,
   input logic [NUM_LANES*32-1:0]     word_o
);

   // edges seen since reset went high, saturating at the pipeline depth
   logic [1:0] live;
   always_ff @(posedge clk) begin
      if (!rst_n)          live <= '0;
      else if (live != 2'd2) live <= live + 2'd1;
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (word_o == '0)); // R1

   AST_BX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (live == 2'd2) |-> (word_o[25 +: BX_W] == $past(bx_num, 2))); // R6

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
      AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         word_o[l*32+30 +: 2] == 2'b00); // R5

      AST_VC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         (live == 2'd2) |-> (word_o[l*32+24] == $past(cand_vc[l], 2))); // R5

      AST_ETA_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
         (live == 2'd2) |-> (word_o[l*32+21] ==
            ($past(cand_src[l*SRC_W +: SRC_W], 2) >= SRC_W'(FAR_SRC)))); // R4

      AST_ETA_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
         (live == 2'd2) |-> (word_o[l*32+16 +: LETA_W] >=
            $past(cand_leta[l*LETA_W +: LETA_W], 2))); // R4
   end

endmodule

bind muon_word_packer mwp_checker #(
   .NUM_LANES (NUM_LANES),
   .SRC_W     (SRC_W),
   .LETA_W    (LETA_W),
   .BX_W      (BX_W),
   .FAR_SRC   (FAR_SRC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cand_vc   (cand_vc),
   .cand_src  (cand_src),
   .cand_leta (cand_leta),
   .bx_num    (bx_num),
   .word_o    (word_o)
);

// File: tb/muon_word_packer_test.sv
module muon_word_packer_test;

   localparam int CLK_PERIOD = 10;
   localparam int N = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N*7-1:0] cand_rank = '0;
   logic [N-1:0]   cand_vc = '0;
   logic [N*5-1:0] cand_lphi = '0;
   logic [N*4-1:0] cand_src = '0;
   logic [N*5-1:0] cand_leta = '0;
   logic [N-1:0]   cand_sign = '0;
   logic [N-1:0]   cand_halo = '0;
   logic [2:0]     bx_num = '0;
   logic           bx_zero = 1'b0;
   logic           sync_err = 1'b0;
   logic           host_we = 1'b0;
   logic           host_sel = 1'b0;
   logic [8:0]     host_addr = '0;
   logic [7:0]     host_wdata = '0;
   logic [N*32-1:0] word_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   muon_word_packer uut (
      .clk(clk), .rst_n(rst_n),
      .cand_rank(cand_rank), .cand_vc(cand_vc), .cand_lphi(cand_lphi),
      .cand_src(cand_src), .cand_leta(cand_leta), .cand_sign(cand_sign),
      .cand_halo(cand_halo), .bx_num(bx_num), .bx_zero(bx_zero),
      .sync_err(sync_err), .host_we(host_we), .host_sel(host_sel),
      .host_addr(host_addr), .host_wdata(host_wdata), .word_o(word_o)
   );

   int n_chk = 0;
   int n_fail = 0;

   // software copies of the tables
   logic [7:0] m_ptq [256];
   logic [7:0] m_phi [512];

   // candidate fields as the bench sees them
   logic [6:0] rk [N];
   logic       vc [N];
   logic [4:0] lp [N];
   logic [3:0] sr [N];
   logic [4:0] le [N];
   logic       sg [N];
   logic       hl [N];
   logic [2:0] bx;
   logic       b0;
   logic       se;

   logic [31:0] pipe_exp [2][N];
   bit          pipe_v [2];
   string       pipe_tag [2];

   function automatic logic [5:0] eta_model(logic [3:0] s, logic [4:0] e);
      int off;
      int sum;
      off = (s >= 4'd6) ? int'(s) - 6 : int'(s);
      sum = int'(e) + off;
      if (sum > 31) sum = 31;
      return {s >= 4'd6, 5'(sum)};
   endfunction

   function automatic logic [31:0] word_model(int l);
      logic [7:0] pq;
      logic [7:0] ph;
      pq = m_ptq[{vc[l], rk[l]}];
      ph = m_phi[{sr[l], lp[l]}];
      return {2'b00, se, b0, bx, vc[l], sg[l], hl[l],
              eta_model(sr[l], le[l]), pq[7:5], pq[4:0], ph};
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_lane(string tag, int l, logic [31:0] got, logic [31:0] exp);
      check($sformatf("R3 phi lane %0d %s", l, tag),     32'(got[7:0]),   32'(exp[7:0]));
      check($sformatf("R2 pt lane %0d %s", l, tag),      32'(got[12:8]),  32'(exp[12:8]));
      check($sformatf("R2 quality lane %0d %s", l, tag), 32'(got[15:13]), 32'(exp[15:13]));
      check($sformatf("R4 eta lane %0d %s", l, tag),     32'(got[21:16]), 32'(exp[21:16]));
      check($sformatf("R5 flags lane %0d %s", l, tag),   32'(got[31:22]), 32'(exp[31:22]));
      check($sformatf("R6 R7 word lane %0d %s", l, tag), got, exp);
   endtask

   // one cycle: check the word due now, then present the next candidates
   task automatic step(bit live, string tag, bit do_w, bit wsel,
                       logic [8:0] wa, logic [7:0] wd);
      @(negedge clk);
      if (pipe_v[1])
         for (int l = 0; l < N; l++)
            check_lane(pipe_tag[1], l, word_o[l*32 +: 32], pipe_exp[1][l]);
      pipe_v[1]   = pipe_v[0];
      pipe_tag[1] = pipe_tag[0];
      for (int l = 0; l < N; l++) pipe_exp[1][l] = pipe_exp[0][l];
      for (int l = 0; l < N; l++) begin
         cand_rank[l*7 +: 7] = rk[l];
         cand_vc[l]          = vc[l];
         cand_lphi[l*5 +: 5] = lp[l];
         cand_src[l*4 +: 4]  = sr[l];
         cand_leta[l*5 +: 5] = le[l];
         cand_sign[l]        = sg[l];
         cand_halo[l]        = hl[l];
      end
      bx_num = bx; bx_zero = b0; sync_err = se;
      host_we = do_w; host_sel = wsel; host_addr = wa; host_wdata = wd;
      pipe_v[0]   = live;
      pipe_tag[0] = tag;
      for (int l = 0; l < N; l++) pipe_exp[0][l] = word_model(l);
      // the table update lands after this cycle's lookup
      if (do_w) begin
         if (wsel) m_phi[wa] = wd;
         else      m_ptq[wa[7:0]] = wd;
      end
   endtask

   task automatic rand_cands();
      for (int l = 0; l < N; l++) begin
         rk[l] = 7'($urandom); vc[l] = 1'($urandom);
         lp[l] = 5'($urandom); sr[l] = 4'($urandom);
         le[l] = 5'($urandom); sg[l] = 1'($urandom);
         hl[l] = 1'($urandom);
      end
      bx = 3'($urandom); b0 = 1'($urandom); se = 1'($urandom);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      pipe_v[0] = 0; pipe_v[1] = 0;
      rand_cands();

      // R1: words stay zero under reset even with busy inputs
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R1 under reset", word_o[31:0], 32'h0);
         check("R1 under reset upper lanes", 32'(|word_o[N*32-1:32]), 32'h0);
         rand_cands();
         step(0, "", 0, 0, '0, '0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first edge after release", 32'(|word_o), 32'h0);

      // R8: fill both tables through the host port
      for (int a = 0; a < 256; a++) step(0, "", 1, 0, 9'(a), 8'($urandom));
      for (int a = 0; a < 512; a++) step(0, "", 1, 1, 9'(a), 8'($urandom));
      step(0, "", 0, 0, '0, '0);
      step(0, "", 0, 0, '0, '0);

      // R4: eta corners (saturation, exact limit, side boundary)
      rand_cands();
      sr[0] = 4'd5;  le[0] = 5'd31;
      sr[1] = 4'd15; le[1] = 5'd31;
      sr[2] = 4'd6;  le[2] = 5'd0;
      sr[3] = 4'd11; le[3] = 5'd26;
      step(1, "R4 corner", 0, 0, '0, '0);
      sr[0] = 4'd0;  le[0] = 5'd0;
      sr[1] = 4'd5;  le[1] = 5'd26;
      sr[2] = 4'd12; le[2] = 5'd25;
      sr[3] = 4'd13; le[3] = 5'd25;
      bx = 3'd7; b0 = 1'b1; se = 1'b1;
      step(1, "R4 R5 corner", 0, 0, '0, '0);

      // R9 then R8: same-address write collides with a lookup
      rand_cands();
      vc[0] = 1'b1; rk[0] = 7'h55;
      step(1, "R9 ptq collision", 1, 0, 9'h0D5, ~m_ptq[8'hD5]);
      step(1, "R8 ptq after write", 0, 0, '0, '0);
      sr[1] = 4'd9; lp[1] = 5'd3;
      step(1, "R9 phi collision", 1, 1, 9'h123, ~m_phi[9'h123]);
      step(1, "R8 phi after write", 0, 0, '0, '0);

      // R6 R7: back-to-back random stream with scattered host writes
      for (int i = 0; i < 300; i++) begin
         bit w;
         rand_cands();
         w = ($urandom % 4) == 0;
         step(1, "R6 stream", w, 1'($urandom), 9'($urandom), 8'($urandom));
      end
      step(0, "", 0, 0, '0, '0);
      step(0, "", 0, 0, '0, '0);
      step(0, "", 0, 0, '0, '0);

      summary();
      $finish;
   end

endmodule